// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block produces the serial clock timing for a byte-level I2C master engine. It runs from a 12 MHz system clock. It divides that clock by one of eight divisors, which a 3-bit rate code selects. A 2-bit table select picks which divisor table applies:

- the nominal table;
- a table at twice the nominal bit rate;
- a table at half the nominal bit rate.

The divisors in a table do not rise with the code. The bit engine uses two outputs. One is a free-running SCL level. The other is a one-cycle phase strobe that marks every point where the SCL level changes.

Each bit period has a low half followed by a high half. The configuration in use is captured only when a bit period begins. Software may therefore rewrite the code or the table select at any time without shortening a phase that is already in progress. While the enable is low, the generator rests with SCL high and no strobes.

Top module: `sclk_rate_gen`

## Requirements
- R1: With table select 00, rate codes 0 to 7 give bit periods of 60, 1600, 40, 30, 240, 3200, 160 and 120 system clocks.
- R2: With table select 01, every bit period is half the nominal one: 30, 800, 20, 15, 120, 1600, 80 and 60 clocks for codes 0 to 7.
- R3: With table select 10, every bit period is double the nominal one: 120, 3200, 80, 60, 480, 6400, 320 and 240 clocks for codes 0 to 7.
- R4: Table select 11 gives exactly the nominal periods of R1.
- R5: A bit period of D clocks has a low half of floor(D/2) clocks followed by a high half of D - floor(D/2) clocks. The low half comes first.
- R6: The phase strobe is high for exactly one clock, in the first clock of each new half. The SCL level changes only in a clock where the strobe is high. The first low half after enabling has no strobe.
- R7: A change to the rate code or table select during a bit period leaves that period unchanged. It applies from the next low half onward.
- R8: While the enable is low, SCL is high and the strobe is low from the next clock on. Once the enable is sampled high, SCL goes low in the following clock and starts a full-length low half with the current configuration.
- R9: After reset, SCL is high and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable for the clock generator |
| rate_code | input | 3 | Divisor selector inside the active table |
| table_sel | input | 2 | 00 nominal, 01 double rate, 10 half rate, 11 as nominal |
| phase_strobe | output | 1 | One-cycle pulse at each SCL half-period boundary |
| scl_level | output | 1 | Generated serial clock level |

## Verification
A wrong divisor entry, or a wrong table scaling, changes the measured length of the first low and high halves after an enable. It is therefore visible within one bit period of the affected code. A configuration register that loads at the wrong moment shows up in the period that spans a mid-period rate change: that period comes out at the new length instead of the old one. A faulty phase counter or strobe register shows up at the next SCL edge, either as a missing strobe or as a strobe in a clock where SCL does not change.

// File: rtl/sclk_rate_pkg.sv
package sclk_rate_pkg;

    localparam int RATE_W    = 3;
    localparam int SEL_W     = 2;
    localparam int NUM_CODES = 1 << RATE_W;
    localparam int NUM_TABLES = 3;

    // Largest nominal divisor, scaled by the half-rate table.
    localparam int NOM_MAX   = 3200;
    localparam int MAX_DIV   = 2 * NOM_MAX;
    localparam int LEN_W     = $clog2(MAX_DIV + 1);

    typedef enum logic [SEL_W-1:0] {
        TBL_NOMINAL  = 2'b00,
        TBL_DOUBLE   = 2'b01,
        TBL_HALF     = 2'b10,
        TBL_RESERVED = 2'b11
    } table_e;

    typedef struct packed {
        logic [LEN_W-1:0] low_len;
        logic [LEN_W-1:0] high_len;
    } half_cfg_t;

    // Nominal divisor per code; deliberately non-monotonic.
    function automatic logic [LEN_W-1:0] nominal_div(input logic [RATE_W-1:0] code);
        logic [LEN_W-1:0] d;
        case (code)
            3'd0:    d = LEN_W'(60);
            3'd1:    d = LEN_W'(1600);
            3'd2:    d = LEN_W'(40);
            3'd3:    d = LEN_W'(30);
            3'd4:    d = LEN_W'(240);
            3'd5:    d = LEN_W'(3200);
            3'd6:    d = LEN_W'(160);
            default: d = LEN_W'(120);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sclk_div_table.sv
module sclk_div_table
    import sclk_rate_pkg::*;
(
    input  logic [RATE_W-1:0] rate_code,
    input  logic [SEL_W-1:0]  table_sel,
    output half_cfg_t         cfg
);

    logic [LEN_W-1:0] base_div;
    logic [LEN_W-1:0] scaled_div [NUM_TABLES];
    logic [LEN_W-1:0] sel_div;
    logic [1:0]       tbl_idx;

    assign base_div = nominal_div(rate_code);

    // One divisor variant per table: nominal, halved divisor, doubled divisor.
    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
        if (t == 1) begin : g_fast
            assign scaled_div[t] = base_div >> 1;
        end else if (t == 2) begin : g_slow
            assign scaled_div[t] = base_div << 1;
        end else begin : g_nom
            assign scaled_div[t] = base_div;
        end
    end

    always_comb begin
        case (table_e'(table_sel))
            TBL_DOUBLE: tbl_idx = 2'd1;
            TBL_HALF:   tbl_idx = 2'd2;
            default:    tbl_idx = 2'd0;   // reserved code falls back to nominal
        endcase
        sel_div      = scaled_div[tbl_idx];
        cfg.low_len  = sel_div >> 1;
        cfg.high_len = sel_div - (sel_div >> 1);
    end

endmodule

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
    import sclk_rate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  half_cfg_t cfg_in,
    output half_cfg_t cfg_out
);

    half_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_out = cfg_q;

endmodule

// File: rtl/sclk_phase_timer.sv
module sclk_phase_timer
    import sclk_rate_pkg::*;
#(
    parameter int CNT_W = LEN_W
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  half_cfg_t cfg,
    output logic      period_load,
    output logic      phase_strobe,
    output logic      scl_level
);

    typedef struct packed {
        logic             run;
        logic             phase;   // 0 = low half, 1 = high half
        logic             strobe;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t           st_d, st_q;
    logic [CNT_W-1:0] cur_len;
    logic             terminal;

    assign cur_len  = st_q.phase ? CNT_W'(cfg.high_len) : CNT_W'(cfg.low_len);
    assign terminal = (st_q.cnt == cur_len - CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '{run: 1'b0, phase: 1'b0, strobe: 1'b0, cnt: '0};
        end else if (!st_q.run) begin
            st_d = '{run: 1'b1, phase: 1'b0, strobe: 1'b0, cnt: '0};
        end else if (terminal) begin
            st_d.phase  = ~st_q.phase;
            st_d.strobe = 1'b1;
            st_d.cnt    = '0;
        end else begin
            st_d.strobe = 1'b0;
            st_d.cnt    = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_load  = !st_q.run || (st_q.phase && terminal);
    assign phase_strobe = st_q.strobe;
    assign scl_level    = !st_q.run || st_q.phase;

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt < cur_len));

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_level && !phase_strobe));

    assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_strobe |=> !phase_strobe);

    assert_edge_marked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && (scl_level != $past(scl_level))) |-> phase_strobe);

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
    import sclk_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate_code,
    input  logic [SEL_W-1:0]  table_sel,
    output logic              phase_strobe,
    output logic              scl_level
);

    half_cfg_t live_cfg;
    half_cfg_t held_cfg;
    logic      load;

    sclk_div_table u_table (
        .rate_code (rate_code),
        .table_sel (table_sel),
        .cfg       (live_cfg)
    );

    sclk_cfg_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .cfg_in  (live_cfg),
        .cfg_out (held_cfg)
    );

    sclk_phase_timer #(.CNT_W(LEN_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .cfg          (held_cfg),
        .period_load  (load),
        .phase_strobe (phase_strobe),
        .scl_level    (scl_level)
    );

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held_cfg));

endmodule

// File: tb/sclk_rate_gen_test.sv
module sclk_rate_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic [1:0] table_sel = 2'd0;
    logic       phase_strobe;
    logic       scl_level;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sclk_rate_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .rate_code    (rate_code),
        .table_sel    (table_sel),
        .phase_strobe (phase_strobe),
        .scl_level    (scl_level)
    );

    function automatic int exp_div(input int code, input int sel);
        int n;
        case (code)
            0: n = 60;   1: n = 1600; 2: n = 40;  3: n = 30;
            4: n = 240;  5: n = 3200; 6: n = 160; default: n = 120;
        endcase
        if (sel == 1) return n / 2;
        if (sel == 2) return n * 2;
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count the low half then the high half, starting at a sample in the low half.
    // Ends on the sample where SCL has fallen again.
    task automatic measure_halves(input string req, output int lo, output int hi);
        lo = 0;
        hi = 0;
        while (scl_level == 1'b0 && lo < 20000) begin
            lo++;
            @(negedge clk);
        end
        check(req, int'(phase_strobe), 1, "strobe at rising SCL");
        while (scl_level == 1'b1 && hi < 20000) begin
            hi++;
            @(negedge clk);
        end
        check(req, int'(phase_strobe), 1, "strobe at falling SCL");
    endtask

    task automatic run_combo(input string req, input int code, input int sel);
        int lo, hi, d;
        @(negedge clk);
        en = 1'b0;
        rate_code = 3'(code);
        table_sel = 2'(sel);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check(req, int'(phase_strobe), 0, "no strobe at start");
        measure_halves(req, lo, hi);
        d = exp_div(code, sel);
        check(req, lo + hi, d, $sformatf("period code %0d table %0d", code, sel));
        check("R5", lo, d / 2, $sformatf("low half code %0d table %0d", code, sel));
        en = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R9", int'(scl_level), 1, "SCL after reset");
        check("R9", int'(phase_strobe), 0, "strobe after reset");
    endtask

    task automatic test_tables();
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                run_combo(s == 0 ? "R1" : (s == 1 ? "R2" : "R3"), c, s);
            end
        end
    endtask

    task automatic test_reserved();
        for (int c = 0; c < 8; c++) begin
            run_combo("R4", c, 3);
        end
    endtask

    task automatic test_midchange();
        int lo, hi;
        @(negedge clk);
        en = 1'b0;
        rate_code = 3'd0;
        table_sel = 2'd0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        repeat (10) @(negedge clk);
        rate_code = 3'd3;             // nominal 30 clocks
        lo = 10;
        hi = 0;
        while (scl_level == 1'b0 && lo < 20000) begin
            lo++;
            @(negedge clk);
        end
        while (scl_level == 1'b1 && hi < 20000) begin
            hi++;
            @(negedge clk);
        end
        check("R7", lo, 30, "low half kept after change");
        check("R7", hi, 30, "high half kept after change");
        measure_halves("R7", lo, hi);
        check("R7", lo + hi, 30, "next period uses new code");
        en = 1'b0;
    endtask

    task automatic test_disable();
        int lo, hi;
        @(negedge clk);
        rate_code = 3'd7;
        table_sel = 2'd1;             // 60 clocks
        en = 1'b1;
        @(negedge clk);
        repeat (45) @(negedge clk);   // inside the high half
        check("R8", int'(scl_level), 1, "in high half before disable");
        en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check("R8", int'(scl_level), 1, "SCL while disabled");
            check("R8", int'(phase_strobe), 0, "strobe while disabled");
            @(negedge clk);
        end
        en = 1'b1;
        @(negedge clk);
        check("R8", int'(scl_level), 0, "SCL low after enable");
        measure_halves("R8", lo, hi);
        check("R8", lo, 30, "fresh low half");
        check("R8", hi, 30, "fresh high half");
        en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_tables();
        test_reserved();
        test_midchange();
        test_disable();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule